// File: doc/BRIEF.md
# Peripheral Interrupt Routing Matrix

This block steers a bank of peripheral interrupt request lines onto a smaller set of core interrupt inputs. Every source owns a 4-bit destination code. The code either names one of the core lines or leaves the source unconnected. The codes are packed four to a 16-bit word. Software reaches those words through a plain register port that has an address, a write strobe, write data and combinational read data.

Each core line is the OR of every source whose code names it, so any number of sources may share a line. The core lines are ordered by priority, and line 0 is the most urgent. Because the block only decides which line a source drives, software sets the urgency of a peripheral by where it routes that peripheral. The requests are levels. After one register stage a core line follows its sources and stays high as long as any of them does. After reset every source is unconnected.

Top module: `irq_route_matrix`

## Requirements
- R1: While reset is asserted, and on leaving it, every route word reads 0xFFFF and every core line is low, whatever the sources do.
- R2: A write (`cfg_wr` high at a rising edge) stores `cfg_wdata` in word `cfg_addr`, and the stored value appears on `cfg_rdata` for that address from the following cycle.
- R3: A source whose code is 0x0 to 0xB drives core line 0 to 11 respectively. The line rises at the first rising edge that samples the source high.
- R4: A source whose code is 0xC, 0xD, 0xE or 0xF drives no core line.
- R5: A core line is high when at least one of the sources routed to it is high, and a line may be shared by any number of sources.
- R6: Source n takes its code from word n/4, bits [4*(n%4)+3 : 4*(n%4)], so nibble 0 occupies bits [3:0].
- R7: A core line stays high for every cycle in which a routed source is held high. It falls at the first edge that samples all of its routed sources low.
- R8: When `cfg_wr` is low, the address and write data have no effect on any stored word.
- R9: A single active source drives at most one core line.
- R10: A new code takes effect on the outputs from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 3 | Route word select, 0 to 7 |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 16 | Data to write: four 4-bit codes |
| cfg_rdata | output | 16 | Stored word at `cfg_addr` (combinational) |
| src_irq | input | 32 | Level-sensitive peripheral requests |
| core_irq | output | 12 | Registered core interrupt lines, index 0 most urgent |

## Verification
The hardest case to reach is a remap. A code changes under a source that is already held high, and the bench must see the request move from one line to another at exactly the edge after the write. The bench first programs a known table and walks source patterns through it. It then rewrites single nibbles in the upper words while a source stays asserted, so that a misplaced nibble or a stale code shows up on the wrong line. It also routes all 32 sources onto one line to exercise the widest OR.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned CODE_W = 4;
  localparam int unsigned WORD_W = 16;

  // Codes at or above the line count are "not connected"; reset uses all ones.
  localparam logic [CODE_W-1:0] CODE_OFF = '1;

  typedef logic [CODE_W-1:0] route_code_t;

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned WORD_W_P = WORD_W,
  parameter int unsigned CODE_W_P = CODE_W,
  localparam int unsigned PER_WORD = WORD_W_P / CODE_W_P,
  localparam int unsigned N_WORD   = N_SRC / PER_WORD,
  localparam int unsigned ADDR_W   = (N_WORD > 1) ? $clog2(N_WORD) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic                       wr_en,
  input  logic [WORD_W_P-1:0]        wr_data,
  output logic [WORD_W_P-1:0]        rd_data,
  output logic [N_SRC*CODE_W_P-1:0]  codes_flat
);

  logic [WORD_W_P-1:0] word_q [N_WORD];

  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '1;
      end else if (wr_en && (wr_addr == ADDR_W'(w))) begin
        word_q[w] <= wr_data;
      end
    end
    // Word w carries sources w*PER_WORD .. w*PER_WORD+PER_WORD-1, low nibble first.
    assign codes_flat[w*WORD_W_P +: WORD_W_P] = word_q[w];
  end

  always_comb begin
    rd_data = word_q[wr_addr];
  end

endmodule

// File: rtl/irq_route_fanin.sv
module irq_route_fanin #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_LINE = 12,
  parameter int unsigned CODE_W = 4
) (
  input  logic [N_SRC-1:0]          src_lvl,
  input  logic [N_SRC*CODE_W-1:0]   codes_flat,
  output logic [N_LINE-1:0]         line_hit
);

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    logic [N_SRC-1:0] sel;
    for (genvar n = 0; n < N_SRC; n++) begin : g_src
      assign sel[n] = (codes_flat[n*CODE_W +: CODE_W] == CODE_W'(l));
    end
    assign line_hit[l] = |(sel & src_lvl);
  end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_LINE = 12,
  localparam int unsigned PER_WORD = WORD_W / CODE_W,
  localparam int unsigned N_WORD   = N_SRC / PER_WORD,
  localparam int unsigned ADDR_W   = (N_WORD > 1) ? $clog2(N_WORD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [N_SRC-1:0]  src_irq,
  output logic [N_LINE-1:0] core_irq
);

  logic [N_SRC*CODE_W-1:0] codes_flat;
  logic [N_LINE-1:0]       line_hit;

  irq_route_regs #(
    .N_SRC    (N_SRC),
    .WORD_W_P (WORD_W),
    .CODE_W_P (CODE_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_addr    (cfg_addr),
    .wr_en      (cfg_wr),
    .wr_data    (cfg_wdata),
    .rd_data    (cfg_rdata),
    .codes_flat (codes_flat)
  );

  irq_route_fanin #(
    .N_SRC  (N_SRC),
    .N_LINE (N_LINE),
    .CODE_W (CODE_W)
  ) u_fanin (
    .src_lvl    (src_irq),
    .codes_flat (codes_flat),
    .line_hit   (line_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_irq <= '0;
    end else begin
      core_irq <= line_hit;
    end
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_LINE = 12,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr,
  input logic [WORD_W-1:0] cfg_wdata,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic [N_SRC-1:0]  src_irq,
  input logic [N_LINE-1:0] core_irq
);

  AST_RESET_QUIET: assert property (@(posedge clk) (!rst_n) |=> (core_irq == '0)); // R1

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata)))); // R2

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr) |=> ((cfg_addr != $past(cfg_addr)) || $stable(cfg_rdata))); // R8

  AST_SILENT_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq == '0) |=> (core_irq == '0)); // R7

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(src_irq) <= 1) |=> $onehot0(core_irq)); // R9

endmodule

bind irq_route_matrix irq_route_chk #(
  .N_SRC  (N_SRC),
  .N_LINE (N_LINE),
  .ADDR_W (ADDR_W),
  .WORD_W (irq_route_pkg::WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_addr  (cfg_addr),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .src_irq   (src_irq),
  .core_irq  (core_irq)
);

// File: tb/sim_irq_route_matrix.sv
module sim_irq_route_matrix;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {source pattern, expected lines} under table code(n) = n % 16
  localparam logic [43:0] VEC [NVEC] = '{
    {32'h0000_0001, 12'h001},
    {32'h0001_0000, 12'h001},
    {32'h0000_1000, 12'h000},
    {32'h0000_F000, 12'h000},
    {32'h0000_0800, 12'h800},
    {32'h0003_0003, 12'h003},
    {32'hFFFF_FFFF, 12'hFFF},
    {32'h00F0_0000, 12'h0F0},
    {32'hF000_F000, 12'h000},
    {32'h0000_0A00, 12'hA00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [31:0] src_irq = '0;
  logic [11:0] core_irq;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_matrix u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .src_irq   (src_irq),
    .core_irq  (core_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    cfg_addr = a;
    #1;
    chk(req, {16'h0, cfg_rdata}, {16'h0, exp});
  endtask

  // drive at a falling edge, look one falling edge later (one register stage)
  task automatic apply(input logic [31:0] s);
    @(negedge clk);
    src_irq = s;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, sources active during reset
    src_irq = '1;
    repeat (3) @(negedge clk);
    chk("R1 lines in reset", {20'h0, core_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lines after reset", {20'h0, core_irq}, 32'h0);
    for (int w = 0; w < 8; w++) rd_chk("R1 word reset value", 3'(w), 16'hFFFF);
    src_irq = '0;

    // R8: address and data without strobe change nothing
    @(negedge clk);
    cfg_addr = 3'd2; cfg_wdata = 16'h1234;
    @(negedge clk);
    rd_chk("R8 no strobe", 3'd2, 16'hFFFF);

    // R2, R6: program code(n) = n % 16
    for (int w = 0; w < 8; w++) begin
      logic [15:0] d;
      for (int k = 0; k < 4; k++) d[4*k +: 4] = 4'((w*4 + k) % 16);
      wr_word(3'(w), d);
    end
    rd_chk("R2 readback w0", 3'd0, 16'h3210);
    rd_chk("R2 readback w2", 3'd2, 16'hBA98);
    rd_chk("R2 readback w7", 3'd7, 16'hFEDC);

    // R3 R4 R5: table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][43:12]);
      chk("R3 R4 R5 table", {20'h0, core_irq}, {20'h0, VEC[i][11:0]});
    end
    apply('0);
    chk("R7 all low", {20'h0, core_irq}, 32'h0);

    // R7: level held for several cycles, falls one edge after release
    @(negedge clk);
    src_irq = 32'h0000_0004;   // source 2 -> line 2
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R7 held high", {20'h0, core_irq}, 32'h004);
    end
    src_irq = '0;
    @(negedge clk);
    chk("R7 falls after release", {20'h0, core_irq}, 32'h0);

    // R6 R10: remap source 22 (word 5, nibble 2) while asserted
    @(negedge clk);
    src_irq = 32'h0040_0000;   // code 6 -> line 6
    @(negedge clk);
    chk("R6 before remap", {20'h0, core_irq}, 32'h040);
    cfg_addr = 3'd5; cfg_wdata = 16'hF3FF; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R10 old code at write edge", {20'h0, core_irq}, 32'h040);
    @(negedge clk);
    chk("R6 R10 moved to line 3", {20'h0, core_irq}, 32'h008);
    src_irq = 32'h0010_0000;   // source 20 now disconnected (0xF)
    @(negedge clk);
    chk("R4 remapped off", {20'h0, core_irq}, 32'h0);

    // R6: nibble 3 of word 0 -> source 3 to line 11
    wr_word(3'd0, 16'hB0FF);
    apply(32'h0000_0008);
    chk("R6 nibble 3", {20'h0, core_irq}, 32'h800);
    apply(32'h0000_0001);
    chk("R4 source 0 off", {20'h0, core_irq}, 32'h0);

    // R5: every source onto line 5
    for (int w = 0; w < 8; w++) wr_word(3'(w), 16'h5555);
    apply(32'h8000_0000);
    chk("R5 shared top source", {20'h0, core_irq}, 32'h020);
    apply(32'h1234_5678);
    chk("R5 shared many", {20'h0, core_irq}, 32'h020);

    // R1: reset mid-run restores disabled codes
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 reset again", 3'd4, 16'hFFFF);
    apply('1);
    chk("R1 R4 all off after reset", {20'h0, core_irq}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule